// File: doc/BRIEF.md
# Precision Time Counter with Divided Clock and Periodic Pulses

This block is the time base of a precision-time-protocol timer. It runs on an external reference clock. On each reference tick, while its run bit is set, a 64-bit time counter advances by one. The counter does not scale or offset the count: it counts raw reference ticks. From the same reference the block derives a divided clock output, and from two independent down-counters it makes two periodic single-tick pulse outputs. A typical use is to derive fixed-rate strobes, such as a pulse every million ticks and another at twice that rate. These strobes can then be looped back into event inputs elsewhere in the chip.

Software reaches the block through a flat register port: a write strobe, an address, and 32-bit write data, with combinational read data for the same address. The register space is as follows:

| Address | Register |
|---|---|
| 0 | control word; bit 2 is the run bit |
| 1 | upper half of the counter |
| 2 | lower half of the counter |
| 3 | prescale value |
| 4 | period of pulse A |
| 5 | period of pulse B |

The usual bring-up is: write the control word with the run bit clear, preload the counter, program the prescale and the two periods, then set the run bit. The run bit gates the counter, the divider and both pulse generators together.

Top module: `ptp_tick_timer`

## Requirements
- R1: After reset every register reads 0, `clk_out` is low, and both pulse outputs are low.
- R2: A write lands on the reference edge where `wr_en` is high. The register map is: address 0 control, 1 counter bits 63:32, 2 counter bits 31:0, 3 prescale, 4 pulse-A period, 5 pulse-B period. Addresses 6 and 7 read 0 and ignore writes.
- R3: While control bit 2 is 1, the counter increments by exactly one per reference tick, carrying from the lower half into the upper half.
- R4: A write to either counter half replaces that half on that tick. On that tick the counter does not increment, and the other half keeps its value.
- R5: Control bits other than bit 2 are stored and read back but have no effect. Writing 0x00010008 leaves the counter stopped; writing 0x0001000C starts it.
- R6: With a prescale N of 2 or more, `clk_out` repeats every N enabled ticks. It is high for the first floor(N/2) ticks of each repeat, which gives a 50% duty cycle for even N. The divider phase advances only while enabled.
- R7: With a prescale of 0 or 1, `clk_out` follows the reference clock while enabled and is low while disabled.
- R8: On the first tick after the run bit goes from 0 to 1, each pulse down-counter loads its period P. After that, its output is high for exactly one tick, P ticks after the load, and then every P ticks.
- R9: A period of 1 holds the pulse output high on every enabled tick. A period of 0 never produces a pulse.
- R10: A period written while running takes effect at that generator's next reload. The pulse already in progress keeps the old spacing.
- R11: While the run bit is 0, both pulse outputs are low, and the counter, divider phase and down-counters hold their values. Setting the run bit again reloads both periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | External reference clock; every register is clocked by its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the register at `addr` |
| clk_out | output | 1 | Divided (or passed-through) reference clock |
| pulse_a | output | 1 | Periodic single-tick pulse, generator A |
| pulse_b | output | 1 | Periodic single-tick pulse, generator B |

## Verification
The assertions take two things for granted: a single reference clock domain, and that `wr_en`, `addr` and `wr_data` are settled well clear of the rising reference edge. From these they conclude that a counter-half write on one tick fully explains any departure from the increment-or-hold rule on the next. They also assume that the prescale value seen by the divider on a tick is the one that bounds its phase on the following tick. The stimulus honours this: it changes every input a fixed delay after the rising edge and never drives a value during the edge itself. It also exercises prescale changes while running and counter writes that carry across the 32-bit boundary, and each of those still keeps inputs stable around the edge.

// File: rtl/ptp_tick_timer.sv
module ptp_tick_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int RUN_BIT = 2
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_out,
  output logic              pulse_a,
  output logic              pulse_b
);

  localparam int CNT_W = 2 * DATA_W;
  localparam int NCH   = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PER0  = ADDR_W'(4);

  logic [DATA_W-1:0] ctrl_q, presc_q, phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] per_q [NCH];
  logic [DATA_W-1:0] dc_q  [NCH];
  logic [NCH-1:0]    pls_q;
  logic              en_d_q;

  wire run    = ctrl_q[RUN_BIT];
  wire start  = run && !en_d_q;
  wire wr_hi  = wr_en && addr == A_HI;
  wire wr_lo  = wr_en && addr == A_LO;
  wire wr_cnt = wr_hi || wr_lo;
  wire wide   = presc_q >= DATA_W'(2);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      en_d_q  <= 1'b0;
    end else begin
      en_d_q <= run;
      if (wr_en && addr == A_CTRL)  ctrl_q  <= wr_data;
      if (wr_en && addr == A_PRESC) presc_q <= wr_data;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_hi) cnt_q <= {wr_data, cnt_q[DATA_W-1:0]};
    else if (wr_lo) cnt_q <= {cnt_q[CNT_W-1:DATA_W], wr_data};
    else if (run)   cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (run && wide)
      phase_q <= (phase_q >= presc_q - DATA_W'(1)) ? '0 : phase_q + DATA_W'(1);
  end

  assign clk_out = wide ? (phase_q < (presc_q >> 1)) : (run & ref_clk);

  for (genvar i = 0; i < NCH; i++) begin : g_pulse
    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q[i] <= '0;
        dc_q[i]  <= '0;
        pls_q[i] <= 1'b0;
      end else begin
        if (wr_en && addr == A_PER0 + ADDR_W'(i)) per_q[i] <= wr_data;
        if (!run) begin
          pls_q[i] <= 1'b0;
        end else if (start || dc_q[i] <= DATA_W'(1)) begin
          pls_q[i] <= !start && dc_q[i] == DATA_W'(1);
          dc_q[i]  <= per_q[i];
        end else begin
          pls_q[i] <= 1'b0;
          dc_q[i]  <= dc_q[i] - DATA_W'(1);
        end
      end
    end

    assert_reload_on_start_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      start |=> dc_q[i] == $past(per_q[i]));
    assert_quiet_when_stopped_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> !pls_q[i]);
    assert_dc_hold_when_stopped_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !$past(run) |-> dc_q[i] == $past(dc_q[i]));
  end

  assign pulse_a = pls_q[0];
  assign pulse_b = pls_q[1];

  always_comb begin
    case (addr)
      A_CTRL:                rd_data = ctrl_q;
      A_HI:                  rd_data = cnt_q[CNT_W-1:DATA_W];
      A_LO:                  rd_data = cnt_q[DATA_W-1:0];
      A_PRESC:               rd_data = presc_q;
      A_PER0:                rd_data = per_q[0];
      A_PER0 + ADDR_W'(1):   rd_data = per_q[1];
      default:               rd_data = '0;
    endcase
  end

  assert_count_step_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(run) && !$past(wr_cnt)) |-> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_count_hold_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!$past(run) && !$past(wr_cnt)) |-> cnt_q == $past(cnt_q));
  assert_phase_in_range_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (run && wide) |=> phase_q < $past(presc_q));
  assert_low_half_kept_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(wr_hi) |-> cnt_q[DATA_W-1:0] == $past(cnt_q[DATA_W-1:0]));

endmodule

// File: tb/ptp_tick_timer_bench.sv
module ptp_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out, pulse_a, pulse_b;

  ptp_tick_timer u_ptp_tick_timer (
    .ref_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out), .pulse_a(pulse_a), .pulse_b(pulse_b));

  always #10 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string cur = "R1";
  bit    done = 1'b0;
  int    rot = 0;

  logic [31:0] m_ctrl, m_presc, m_phase;
  logic [63:0] m_cnt;
  logic [31:0] m_per [2];
  logic [31:0] m_dc  [2];
  logic        m_pls [2];
  logic        m_en_d;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_cnt[63:32];
      3'd2: return m_cnt[31:0];
      3'd3: return m_presc;
      3'd4: return m_per[0];
      3'd5: return m_per[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_clk(logic lvl);
    if (m_presc >= 2) return m_phase < (m_presc >> 1);
    return m_ctrl[2] & lvl;
  endfunction

  // behavioural reference model, advanced on every reference edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_presc = 0; m_phase = 0; m_cnt = 0; m_en_d = 0;
      for (int i = 0; i < 2; i++) begin m_per[i] = 0; m_dc[i] = 0; m_pls[i] = 0; end
    end else begin
      bit en;
      en = m_ctrl[2];
      if (en && m_presc >= 2) m_phase = (m_phase >= m_presc - 1) ? 0 : m_phase + 1;
      for (int i = 0; i < 2; i++) begin
        if (!en) m_pls[i] = 0;
        else if (!m_en_d) begin m_dc[i] = m_per[i]; m_pls[i] = 0; end
        else if (m_dc[i] == 1) begin m_pls[i] = 1; m_dc[i] = m_per[i]; end
        else if (m_dc[i] == 0) begin m_pls[i] = 0; m_dc[i] = m_per[i]; end
        else begin m_pls[i] = 0; m_dc[i] = m_dc[i] - 1; end
      end
      m_en_d = en;
      if (wr_en && addr == 1) m_cnt[63:32] = wr_data;
      else if (wr_en && addr == 2) m_cnt[31:0] = wr_data;
      else if (en) m_cnt = m_cnt + 1;
      if (wr_en && addr == 0) m_ctrl = wr_data;
      if (wr_en && addr == 3) m_presc = wr_data;
      if (wr_en && addr == 4) m_per[0] = wr_data;
      if (wr_en && addr == 5) m_per[1] = wr_data;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check(cur, "rd_data", rd_data, exp_rd(addr));
    check(cur, "pulse_a", pulse_a, m_pls[0]);
    check(cur, "pulse_b", pulse_b, m_pls[1]);
    check(cur, "clk_out low phase", clk_out, exp_clk(1'b0));
  end

  always @(posedge clk) if (rst_n && !done) begin
    #7 check(cur, "clk_out high phase", clk_out, exp_clk(1'b1));
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #4; wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #4; wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #4; wr_en = 1'b0; addr = 3'(rot); rot++;
    end
  endtask

  task automatic read_at(logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #4; wr_en = 1'b0; addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic count_pulses(int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ca += int'(pulse_a); cb += int'(pulse_b);
    end
  endtask

  initial begin
    logic [31:0] v, v2;
    int ca, cb;
    #35 rst_n = 1'b1;
    cur = "R1";
    for (int a = 0; a < 8; a++) begin
      read_at(3'(a), v);
      check("R1", "reset read", v, 0);
    end
    check("R1", "pulse_a at reset", pulse_a, 0);
    check("R1", "clk_out at reset", clk_out, 0);

    cur = "R5";
    wr(0, 32'h0001_0008);
    wr(2, 32'd5);
    idle(6);
    read_at(2, v);
    check("R5", "stopped count", v, 5);
    read_at(0, v);
    check("R5", "control readback", v, 32'h0001_0008);

    cur = "R2";
    wr(6, 32'hDEAD_BEEF);
    read_at(6, v);
    check("R2", "unmapped addr 6", v, 0);
    wr(3, 32'd4); wr(4, 32'd5); wr(5, 32'd3);
    read_at(4, v);
    check("R2", "period A readback", v, 5);

    cur = "R8";
    wr(0, 32'h0001_000C);
    idle(40);
    count_pulses(50, ca, cb);
    check("R8", "pulses of period 5 in 50 ticks", ca, 10);
    check("R6", "prescale 4 present", m_presc, 4);

    cur = "R3";
    wr(2, 32'hFFFF_FFF0);
    idle(30);
    read_at(1, v);
    check("R3", "carry into upper half", v, 1);

    cur = "R4";
    wr(1, 32'h0000_0ABC);
    read_at(1, v);
    check("R4", "upper half written", v, 32'h0000_0ABC);
    idle(5);

    cur = "R10";
    wr(4, 32'd7);
    idle(40);

    cur = "R6";
    wr(3, 32'd3);
    idle(20);
    wr(3, 32'd6);
    idle(24);

    cur = "R7";
    wr(3, 32'd1);
    idle(10);
    wr(3, 32'd0);
    idle(10);

    cur = "R9";
    wr(5, 32'd1);
    wr(4, 32'd0);
    wr(0, 32'h0);
    wr(0, 32'h4);
    idle(3);
    count_pulses(20, ca, cb);
    check("R9", "period 1 always high", cb, 20);
    check("R9", "period 0 never pulses", ca, 0);

    cur = "R11";
    wr(3, 32'd4);
    wr(4, 32'd6);
    wr(0, 32'h0001_0008);
    read_at(2, v);
    idle(12);
    read_at(2, v2);
    check("R11", "count held while stopped", v2, v);
    count_pulses(10, ca, cb);
    check("R11", "no pulses while stopped", ca + cb, 0);
    wr(0, 32'h0001_000C);
    idle(30);

    cur = "R8";
    wr(4, 32'd1000);
    wr(5, 32'd500);
    wr(0, 32'h0);
    wr(0, 32'h4);
    idle(2);
    count_pulses(3000, ca, cb);
    check("R8", "period 1000 over 3000 ticks", ca, 3);
    check("R8", "period 500 over 3000 ticks", cb, 6);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule